// File: doc/BRIEF.md
# Interval Timer with Count Snapshot

A 32-bit down-counting interval timer sitting on a simple word-addressed register bus. Software loads a reload value as two 16-bit halves, chooses one-shot or continuous operation, enables the interrupt and starts the timer with a write-only strobe. The counter moves down by one on every cycle where the external count-enable input is high and the timer is running. When it steps down from zero, the timer raises a timeout flag and reloads the period. A full period therefore lasts period+1 enabled cycles.

Software reads the live count through a snapshot pair. A write to either snapshot word latches the whole counter into both halves in the same cycle, so the two halves always form a consistent 32-bit value. The interrupt output is a level signal: the timeout flag masked by the interrupt enable. Any write to the status word clears the timeout flag. Reads are combinational. Writes take a single-cycle strobe and have no wait states.

Top module: `interval_timer`

## Requirements
- R1: After reset every readable word reads zero, the timer is stopped, irq_o is low, and the counter holds all ones. A snapshot taken before any period write reads 0xFFFF in both halves.
- R2: Words sit at word addresses 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low and 5 snapshot high. Addresses 6 and above read zero, and writes to them change nothing.
- R3: Control bit 0 is the interrupt enable and bit 1 selects continuous mode. Only these two bits are stored and read back. Bits 2 and 3 always read zero.
- R4: Status bit 1 is the running flag. Control bit 2 is a start strobe and takes effect only while the timer is stopped. Control bit 3 is a stop strobe and clears the running flag. When both strobes are written together, the timer ends up stopped.
- R5: Status bit 0 is the timeout flag. Any write to word 0 clears it, whatever the data. If an expiry falls in the same cycle as the write, the expiry wins.
- R6: A write to either period word keeps only data bits 15:0. It stops the timer and loads the counter with {period high, period low}.
- R7: While running, the counter decrements once per cycle in which cnt_en_i is high. It holds while the timer is stopped or cnt_en_i is low. An expiry occurs on the enabled cycle in which the counter is zero, so a period value P gives P+1 enabled cycles.
- R8: On expiry the timeout flag is set and the counter reloads the period. In continuous mode the timer keeps running. In one-shot mode the running flag clears and the counter holds the period value.
- R9: A write to word 4 or word 5 captures the counter value present in that cycle: bits 15:0 go to word 4 and bits 31:16 go to word 5.
- R10: irq_o equals timeout flag AND interrupt enable, and follows either input without added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count enable (prescaled tick) |
| wr_i | input | 1 | Single-cycle write strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Combinational read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Directed sequences cover the following cases:
- A period of 2 in one-shot mode must time out after exactly three enabled cycles and then hold the period value.
- The same period in continuous mode must keep running after expiry.
- Start and stop strobes are written from both run states, which separates ignored strobes from effective ones.
- The case where both strobes are written together is included.
- Period writes while running, snapshot writes, and writes to unmapped addresses each show a distinct side effect, or none.

A long random phase then mixes reads, writes to every address, small periods and a gated count enable, against a cycle model kept in the bench. This exposes ordering faults where an expiry, a snapshot and a register write land in the same cycle.

// File: rtl/it_pkg.sv
package it_pkg;
  localparam int unsigned NREG      = 6;
  localparam int unsigned OFF_STAT  = 0;
  localparam int unsigned OFF_CTRL  = 1;
  localparam int unsigned OFF_PLO   = 2;
  localparam int unsigned OFF_PHI   = 3;
  localparam int unsigned OFF_SLO   = 4;
  localparam int unsigned OFF_SHI   = 5;
  localparam int unsigned ST_TO     = 0;
  localparam int unsigned ST_RUN    = 1;
  localparam int unsigned CT_IEN    = 0;
  localparam int unsigned CT_CONT   = 1;
  localparam int unsigned CT_START  = 2;
  localparam int unsigned CT_STOP   = 3;
endpackage

// File: rtl/it_counter.sv
module it_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic tick;
  assign tick     = run_i && en_i;
  assign expire_o = tick && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '1;
    else if (load_i)    cnt_o <= load_val_i;
    else if (expire_o)  cnt_o <= reload_val_i;
    else if (tick)      cnt_o <= cnt_o - 1'b1;
  end

  // R7: one step down per enabled running cycle
  a_r7_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !load_i && (cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);

  // R8: expiry reloads the period
  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !load_i |=> cnt_o == $past(reload_val_i));

  // R7: stopped counter holds
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !load_i |=> $stable(cnt_o));
endmodule

// File: rtl/it_regs.sv
module it_regs
  import it_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NREG-1:0]   sel_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic              run_o,
  output logic              to_o,
  output logic              ien_o,
  output logic              cont_o,
  output logic [HALF_W-1:0] plo_o,
  output logic [HALF_W-1:0] phi_o,
  output logic [HALF_W-1:0] slo_o,
  output logic [HALF_W-1:0] shi_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  logic              run_d, to_d;
  logic [HALF_W-1:0] plo_d, phi_d;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[CNT_W-1:HALF_W];

  assign plo_d      = sel_i[OFF_PLO] ? wdata_i[HALF_W-1:0] : plo_o;
  assign phi_d      = sel_i[OFF_PHI] ? wdata_i[HALF_W-1:0] : phi_o;
  assign load_o     = sel_i[OFF_PLO] || sel_i[OFF_PHI];
  assign load_val_o = {phi_d, plo_d};

  always_comb begin
    to_d = to_o;
    if (sel_i[OFF_STAT]) to_d = 1'b0;
    if (expire_i)        to_d = 1'b1;
  end

  always_comb begin
    run_d = run_o;
    if (expire_i && !cont_o) run_d = 1'b0;
    if (sel_i[OFF_CTRL]) begin
      if (wdata_i[CT_STOP])                 run_d = 1'b0;
      else if (wdata_i[CT_START] && !run_o) run_d = 1'b1;
    end
    if (load_o) run_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      to_o   <= 1'b0;
      ien_o  <= 1'b0;
      cont_o <= 1'b0;
      plo_o  <= '0;
      phi_o  <= '0;
      slo_o  <= '0;
      shi_o  <= '0;
    end else begin
      run_o <= run_d;
      to_o  <= to_d;
      plo_o <= plo_d;
      phi_o <= phi_d;
      if (sel_i[OFF_CTRL]) begin
        ien_o  <= wdata_i[CT_IEN];
        cont_o <= wdata_i[CT_CONT];
      end
      if (sel_i[OFF_SLO] || sel_i[OFF_SHI]) begin
        slo_o <= cnt_i[HALF_W-1:0];
        shi_o <= cnt_i[CNT_W-1:HALF_W];
      end
    end
  end

  a_r4_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i[OFF_CTRL] && wdata_i[CT_STOP] |=> !run_o);

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i[OFF_STAT] && !expire_i |=> !to_o);

  a_r8_set_to: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> to_o);

  a_r8_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !cont_o |=> !run_o);

  a_r6_period_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !run_o);

  a_r9_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i[OFF_SLO] || sel_i[OFF_SHI] |=> {shi_o, slo_o} == $past(cnt_i));
endmodule

// File: rtl/it_rdmux.sv
module it_rdmux
  import it_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = CNT_W / 2,
  parameter int unsigned AW     = 4
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              run_i,
  input  logic              to_i,
  input  logic              ien_i,
  input  logic              cont_i,
  input  logic [HALF_W-1:0] plo_i,
  input  logic [HALF_W-1:0] phi_i,
  input  logic [HALF_W-1:0] slo_i,
  input  logic [HALF_W-1:0] shi_i,
  output logic [CNT_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFF_STAT)) begin
      rdata_o[ST_TO]  = to_i;
      rdata_o[ST_RUN] = run_i;
    end else if (addr_i == AW'(OFF_CTRL)) begin
      rdata_o[CT_IEN]  = ien_i;
      rdata_o[CT_CONT] = cont_i;
    end
    else if (addr_i == AW'(OFF_PLO)) rdata_o[HALF_W-1:0] = plo_i;
    else if (addr_i == AW'(OFF_PHI)) rdata_o[HALF_W-1:0] = phi_i;
    else if (addr_i == AW'(OFF_SLO)) rdata_o[HALF_W-1:0] = slo_i;
    else if (addr_i == AW'(OFF_SHI)) rdata_o[HALF_W-1:0] = shi_i;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import it_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned AW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [NREG-1:0]   sel;
  logic              run, to, ien, cont, expire, load;
  logic [HALF_W-1:0] plo, phi, slo, shi;
  logic [CNT_W-1:0]  cnt, load_val;

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign sel[k] = wr_i && (addr_i == AW'(k));
  end

  it_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .en_i(cnt_en_i),
    .load_i(load), .load_val_i(load_val), .reload_val_i({phi, plo}),
    .cnt_o(cnt), .expire_o(expire)
  );

  it_regs #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .wdata_i(wdata_i),
    .cnt_i(cnt), .expire_i(expire), .run_o(run), .to_o(to),
    .ien_o(ien), .cont_o(cont), .plo_o(plo), .phi_o(phi),
    .slo_o(slo), .shi_o(shi), .load_o(load), .load_val_o(load_val)
  );

  it_rdmux #(.CNT_W(CNT_W), .HALF_W(HALF_W), .AW(AW)) u_rd (
    .addr_i(addr_i), .run_i(run), .to_i(to), .ien_i(ien), .cont_i(cont),
    .plo_i(plo), .phi_i(phi), .slo_i(slo), .shi_i(shi), .rdata_o(rdata_o)
  );

  assign irq_o = to && ien;

  // R10: a set flag with enable raises the line in the following cycle
  a_r10_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && ien && !(wr_i && addr_i == AW'(OFF_CTRL)) |=> irq_o);
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  localparam int CLK_NS = 20;
  localparam int CW = 32;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0, en = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0, rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit m_run, m_to, m_ien, m_cont;
  logic [15:0] m_plo, m_phi, m_slo, m_shi;
  logic [31:0] m_cnt;

  always #(CLK_NS/2) clk = ~clk;

  interval_timer #(.CNT_W(CW), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(int a);
    case (a)
      0: return {30'd0, m_run, m_to};
      1: return {30'd0, m_cont, m_ien};
      2: return {16'd0, m_plo};
      3: return {16'd0, m_phi};
      4: return {16'd0, m_slo};
      5: return {16'd0, m_shi};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      0: return "R8";
      1: return "R3";
      2, 3: return "R6";
      4, 5: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic mreset();
    m_run = 0; m_to = 0; m_ien = 0; m_cont = 0;
    m_plo = 0; m_phi = 0; m_slo = 0; m_shi = 0; m_cnt = '1;
  endtask

  task automatic mstep(bit we, int a, logic [31:0] d, bit e);
    bit ex, dc, n_run, n_to;
    logic [31:0] n_cnt;
    ex = m_run && e && (m_cnt == 0);
    dc = m_run && e && (m_cnt != 0);
    n_cnt = ex ? {m_phi, m_plo} : (dc ? m_cnt - 1 : m_cnt);
    n_to = m_to;
    if (we && a == 0) n_to = 0;
    if (ex) n_to = 1;
    n_run = m_run;
    if (ex && !m_cont) n_run = 0;
    if (we && a == 4 || we && a == 5) begin
      m_slo = m_cnt[15:0]; m_shi = m_cnt[31:16];
    end
    if (we && a == 1) begin
      if (d[3]) n_run = 0;
      else if (d[2] && !m_run) n_run = 1;
      m_ien = d[0]; m_cont = d[1];
    end
    if (we && (a == 2 || a == 3)) begin
      if (a == 2) m_plo = d[15:0]; else m_phi = d[15:0];
      n_run = 0;
      n_cnt = {m_phi, m_plo};
    end
    m_run = n_run; m_to = n_to; m_cnt = n_cnt;
  endtask

  // one bus cycle: check combinational outputs against model, then clock
  task automatic cyc(bit we, int a, logic [31:0] d, bit e);
    @(negedge clk);
    wr = we; addr = AW'(a); wdata = d; en = e;
    #1;
    chk(req_of(a), rdata, mread(a));
    chk("R10", {31'd0, irq}, {31'd0, m_to && m_ien});
    mstep(we, a, d, e);
    @(posedge clk);
  endtask

  task automatic peek(int a, output logic [31:0] v);
    @(negedge clk);
    wr = 0; en = 0; addr = AW'(a);
    #1;
    v = rdata;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed_d;
    seed_d = $urandom(32'h5eed_1234);
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      peek(a, v);
      chk("R1", v, 32'd0);
    end
    chk("R1", {31'd0, irq}, 32'd0);
    cyc(1, 4, 0, 0);
    peek(4, v); chk("R1", v, 32'h0000_FFFF);
    peek(5, v); chk("R1", v, 32'h0000_FFFF);

    // R7 one-shot, period 2 => three enabled cycles
    cyc(1, 2, 2, 0);
    cyc(1, 3, 0, 0);
    cyc(1, 1, 32'h5, 0);
    repeat (2) cyc(0, 0, 0, 1);
    peek(0, v); chk("R7", v, 32'd2);
    cyc(0, 0, 0, 1);
    peek(0, v); chk("R7", v, 32'd1);
    chk("R10", {31'd0, irq}, 32'd1);
    cyc(1, 5, 0, 0);
    peek(4, v); chk("R8", v, 32'd2);

    // R5 status write clears timeout
    cyc(1, 0, 32'h0000_FFFF, 0);
    peek(0, v); chk("R5", v, 32'd0);
    chk("R10", {31'd0, irq}, 32'd0);

    // R3 / R4 both strobes from stopped
    cyc(1, 1, 32'hF, 0);
    peek(1, v); chk("R3", v, 32'd3);
    peek(0, v); chk("R4", v, 32'd0);
    cyc(1, 1, 32'h6, 0);
    peek(0, v); chk("R4", v, 32'd2);
    cyc(1, 1, 32'h6, 0);
    peek(0, v); chk("R4", v, 32'd2);

    // R8 continuous keeps running
    repeat (3) cyc(0, 0, 0, 1);
    peek(0, v); chk("R8", v, 32'd3);
    cyc(1, 1, 32'hA, 0);
    peek(0, v); chk("R4", v, 32'd1);

    // R2 unmapped
    cyc(1, 7, 32'hFFFF_FFFF, 0);
    peek(7, v); chk("R2", v, 32'd0);
    peek(1, v); chk("R2", v, 32'd2);

    // R6 period write stops and truncates
    cyc(1, 1, 32'h6, 0);
    cyc(1, 2, 32'hABCD_1234, 0);
    peek(2, v); chk("R6", v, 32'h1234);
    peek(0, v); chk("R6", v, 32'd1);
    repeat (2) cyc(0, 0, 0, 1);
    cyc(1, 4, 0, 0);
    peek(4, v); chk("R9", v, 32'h1234);
    peek(5, v); chk("R9", v, 32'd0);

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      int op, a;
      logic [31:0] d;
      bit e;
      op = $urandom % 10;
      e  = ($urandom % 4) != 0;
      if (op < 5) begin
        cyc(0, $urandom % 16, $urandom, e);
      end else begin
        a = $urandom % 8;
        case (a)
          1: d = $urandom % 16;
          2: d = {$urandom % 65536, 16'd0} | ($urandom % 6);
          3: d = {$urandom % 65536, 16'd0};
          default: d = $urandom;
        endcase
        cyc(1, a, d, e);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule